// File: doc/BRIEF.md
# Execute Stage Datapath

This block is the single-cycle part of the execute stage of a 32-bit in-order core. Each cycle it takes one decoded instruction: the two source register indices and values with their readiness flags, an immediate, the program counter and a set of control bits. A source that is not ready takes the value forwarded from the execute/write-back boundary. The resolved operands go to an adder/logic unit, a comparator and a barrel shifter, and every output is registered. The result therefore appears one clock edge after the instruction is presented.

The adder output serves three purposes: the register result of arithmetic operations, the memory address of loads and stores, and the branch target. Whether a branch is taken is decided by a separate comparator, which looks at the two register operands under the branch type. Multiply and divide run in a separate unit. For them this block only issues a start pulse with the resolved operands and tracks the done strobe that comes back.

Top module: `exec_stage`

## Requirements
- R1: The arithmetic/logic opcodes are `inOp` = 0 add, 1 subtract, 2 and, 3 or, 4 xor. Each acts on operand A (`inPc` if `inSelPc`, else source 1) and operand B (`inImm` if `inSelImm`, else source 2). The 32-bit result, modulo 2^32, appears on `outResult` one cycle after the instruction.
- R2: Source k takes `wbVal` in place of its register value only when its ready flag is 0, `wbWrEn` is 1, `wbRd` equals its index, and that index is nonzero. In every other case it uses the register value.
- R3: Opcode 5 is a signed less-than and opcode 6 is an unsigned less-than of source 1 against operand B. Each yields 1 or 0 on `outResult`.
- R4: Opcode 7 is a left shift, 8 a logical right shift and 9 an arithmetic right shift of source 1. The shift amount is the low 5 bits of operand B. The arithmetic shift fills from bit 31.
- R5: `memAddr` is the adder output (A + B). `memWdata` is the resolved source 2. `memRdEn` and `memWrEn` follow `inMemRd` and `inMemWr`, but only when `inValid` is 1.
- R6: `brAddr` is the adder output A + B, with operand A taken from `inPc` when `inSelPc` is set.
- R7: `brEn` is 1 only for a valid instruction with `inIsBranch` set. The branch compares source 1 against source 2 under `inBrType`: 0 equal, 1 not equal, 4 signed less, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal. Types 2 and 3 are never taken.
- R8: `outValid` is 1 (with `outRd` = `inRd`) only for a valid instruction with opcode 0 to 9 that is neither a branch nor a memory access. Opcodes 10 to 15 never raise it.
- R9: Opcode 10 (multiply/divide) raises `mdStart` for one cycle, one cycle after the instruction is presented. `mdOpA` and `mdOpB` carry the resolved sources 1 and 2.
- R10: After a start, the external unit counts as busy until `mdDone` is seen. A multiply/divide instruction that arrives while it is busy gives no start, unless `mdDone` is 1 in the same cycle.
- R11: While `rstN` is low, every output is 0 and the busy state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| inOp | input | 4 | Operation code |
| inBrType | input | 3 | Branch condition code |
| inIsBranch | input | 1 | Instruction is a conditional branch |
| inMemRd | input | 1 | Instruction is a load |
| inMemWr | input | 1 | Instruction is a store |
| inSelPc | input | 1 | Operand A is the program counter |
| inSelImm | input | 1 | Operand B is the immediate |
| inPc | input | 32 | Program counter of the instruction |
| inImm | input | 32 | Immediate value |
| rs1Idx | input | 5 | Source 1 register index |
| rs1Val | input | 32 | Source 1 register value |
| rs1Ready | input | 1 | Source 1 value is current |
| rs2Idx | input | 5 | Source 2 register index |
| rs2Val | input | 32 | Source 2 register value |
| rs2Ready | input | 1 | Source 2 value is current |
| inRd | input | 5 | Destination register index |
| wbWrEn | input | 1 | Write-back boundary holds a register write |
| wbRd | input | 5 | Destination of the write-back boundary |
| wbVal | input | 32 | Value at the write-back boundary |
| mdDone | input | 1 | Multiply/divide unit finished |
| outValid | output | 1 | Register result is valid |
| outRd | output | 5 | Destination of the result |
| outResult | output | 32 | Register result |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memRdEn | output | 1 | Memory read enable |
| memWrEn | output | 1 | Memory write enable |
| brEn | output | 1 | Branch taken |
| brAddr | output | 32 | Branch target |
| mdStart | output | 1 | Multiply/divide start pulse |
| mdOpA | output | 32 | Multiply/divide operand 1 |
| mdOpB | output | 32 | Multiply/divide operand 2 |

## Verification
Every output of this block is due exactly one rising edge after its instruction is held on the inputs. This covers the result and its valid, the memory request, the branch pair and the multiply/divide start. The busy state that gates a later start is updated on that same edge.

The driver changes inputs on the falling edge and queues one expectation per cycle, idle cycles included. The monitor pops that expectation 1 ns after the next rising edge. A response that arrives a cycle early or late is therefore compared against the wrong instruction and is reported. Fields that mean nothing for a given instruction, such as the address on an arithmetic operation, are skipped, while every enable and valid is compared on every cycle.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_AND    = 4'd2,
    OP_OR     = 4'd3,
    OP_XOR    = 4'd4,
    OP_SLT    = 4'd5,
    OP_SLTU   = 4'd6,
    OP_SLL    = 4'd7,
    OP_SRL    = 4'd8,
    OP_SRA    = 4'd9,
    OP_MULDIV = 4'd10
  } opCode_e;

  typedef enum logic [2:0] {
    BR_EQ  = 3'd0,
    BR_NE  = 3'd1,
    BR_LT  = 3'd4,
    BR_GE  = 3'd5,
    BR_LTU = 3'd6,
    BR_GEU = 3'd7
  } brType_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4
  } aluFn_e;

  // strobes from control to datapath, valid for the current input cycle
  typedef struct packed {
    logic       selAlu;
    logic       selCmp;
    logic       selShf;
    aluFn_e     aluFn;
    logic       cmpSigned;
    logic       shRight;
    logic       shArith;
    logic       selPcA;
    logic       selImmB;
    logic       isBranch;
    logic [2:0] brType;
    logic       memRd;
    logic       memWr;
    logic       wrResult;
    logic       mdGo;
  } strobes_t;

endpackage

// File: rtl/exec_fwd.sv
module exec_fwd #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] srcIdx,
  input  logic [W-1:0]  regVal,
  input  logic          srcReady,
  input  logic          wbWrEn,
  input  logic [RW-1:0] wbRd,
  input  logic [W-1:0]  wbVal,
  output logic [W-1:0]  srcOut
);

  logic takeWb;

  always_comb begin
    takeWb = !srcReady && wbWrEn && (wbRd == srcIdx) && (srcIdx != '0);
    srcOut = takeWb ? wbVal : regVal;
  end

  // register zero never picks up a forwarded value
  always_comb begin
    if (srcIdx == '0) begin
      p_zero_src_r2: assert (srcOut == regVal);
    end
  end

endmodule

// File: rtl/exec_ctrl.sv
module exec_ctrl import exec_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] inOp,
  input  logic [2:0] inBrType,
  input  logic       inIsBranch,
  input  logic       inMemRd,
  input  logic       inMemWr,
  input  logic       inSelPc,
  input  logic       inSelImm,
  input  logic       mdDone,
  output strobes_t   strb
);

  logic mdPending;
  logic isMd;

  always_comb begin
    strb          = '0;
    strb.aluFn    = FN_ADD;
    isMd          = 1'b0;
    case (inOp)
      OP_ADD:  begin strb.selAlu = 1'b1; strb.aluFn = FN_ADD; end
      OP_SUB:  begin strb.selAlu = 1'b1; strb.aluFn = FN_SUB; end
      OP_AND:  begin strb.selAlu = 1'b1; strb.aluFn = FN_AND; end
      OP_OR:   begin strb.selAlu = 1'b1; strb.aluFn = FN_OR;  end
      OP_XOR:  begin strb.selAlu = 1'b1; strb.aluFn = FN_XOR; end
      OP_SLT:  begin strb.selCmp = 1'b1; strb.cmpSigned = 1'b1; end
      OP_SLTU: begin strb.selCmp = 1'b1; end
      OP_SLL:  begin strb.selShf = 1'b1; end
      OP_SRL:  begin strb.selShf = 1'b1; strb.shRight = 1'b1; end
      OP_SRA:  begin strb.selShf = 1'b1; strb.shRight = 1'b1; strb.shArith = 1'b1; end
      OP_MULDIV: isMd = 1'b1;
      default: ;
    endcase
    strb.selPcA   = inSelPc;
    strb.selImmB  = inSelImm;
    strb.brType   = inBrType;
    strb.isBranch = inValid && inIsBranch;
    strb.memRd    = inValid && inMemRd;
    strb.memWr    = inValid && inMemWr;
    strb.wrResult = inValid && (strb.selAlu || strb.selCmp || strb.selShf)
                    && !inIsBranch && !inMemRd && !inMemWr;
    strb.mdGo     = inValid && isMd && (!mdPending || mdDone);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdPending <= 1'b0;
    end else if (strb.mdGo) begin
      mdPending <= 1'b1;
    end else if (mdDone) begin
      mdPending <= 1'b0;
    end
  end

  // at most one result unit is selected per instruction
  always_comb begin
    p_unit_onehot_r8: assert ($onehot0({strb.selAlu, strb.selCmp, strb.selShf}));
  end

  // busy state survives until the done strobe arrives
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mdPending && !mdDone) |=> mdPending);

endmodule

// File: rtl/exec_dp.sv
module exec_dp import exec_pkg::*; #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strb,
  input  logic [W-1:0]         inPc,
  input  logic [W-1:0]         inImm,
  input  logic [1:0][RW-1:0]   srcIdx,
  input  logic [1:0][W-1:0]    srcVal,
  input  logic [1:0]           srcReady,
  input  logic [RW-1:0]        inRd,
  input  logic                 wbWrEn,
  input  logic [RW-1:0]        wbRd,
  input  logic [W-1:0]         wbVal,
  output logic                 outValid,
  output logic [RW-1:0]        outRd,
  output logic [W-1:0]         outResult,
  output logic [W-1:0]         memAddr,
  output logic [W-1:0]         memWdata,
  output logic                 memRdEn,
  output logic                 memWrEn,
  output logic                 brEn,
  output logic [W-1:0]         brAddr,
  output logic                 mdStart,
  output logic [W-1:0]         mdOpA,
  output logic [W-1:0]         mdOpB
);

  localparam int SHW = $clog2(W);

  logic [1:0][W-1:0] srcF;

  for (genvar g = 0; g < 2; g++) begin : g_fwd
    exec_fwd #(.W(W), .RW(RW)) fwd_i (
      .srcIdx   (srcIdx[g]),
      .regVal   (srcVal[g]),
      .srcReady (srcReady[g]),
      .wbWrEn   (wbWrEn),
      .wbRd     (wbRd),
      .wbVal    (wbVal),
      .srcOut   (srcF[g])
    );
  end

  logic [W-1:0]   opA, opB, cmpB, aluRes, shfRes, unitRes;
  logic [SHW-1:0] shAmt;
  logic           cmpEq, cmpLtS, cmpLtU, brTaken, sltBit;

  // operand selection
  always_comb begin
    opA  = strb.selPcA  ? inPc  : srcF[0];
    opB  = strb.selImmB ? inImm : srcF[1];
    cmpB = strb.isBranch ? srcF[1] : opB;
  end

  // adder and logic unit
  always_comb begin
    case (strb.aluFn)
      FN_SUB:  aluRes = opA - opB;
      FN_AND:  aluRes = opA & opB;
      FN_OR:   aluRes = opA | opB;
      FN_XOR:  aluRes = opA ^ opB;
      default: aluRes = opA + opB;
    endcase
  end

  // comparator
  always_comb begin
    cmpEq  = (srcF[0] == cmpB);
    cmpLtS = ($signed(srcF[0]) < $signed(cmpB));
    cmpLtU = (srcF[0] < cmpB);
    sltBit = strb.cmpSigned ? cmpLtS : cmpLtU;
  end

  // branch condition decode
  always_comb begin
    case (strb.brType)
      BR_EQ:   brTaken = cmpEq;
      BR_NE:   brTaken = !cmpEq;
      BR_LT:   brTaken = cmpLtS;
      BR_GE:   brTaken = !cmpLtS;
      BR_LTU:  brTaken = cmpLtU;
      BR_GEU:  brTaken = !cmpLtU;
      default: brTaken = 1'b0;
    endcase
  end

  // shifter
  always_comb begin
    shAmt = opB[SHW-1:0];
    if (!strb.shRight) begin
      shfRes = srcF[0] << shAmt;
    end else if (strb.shArith) begin
      shfRes = W'($signed(srcF[0]) >>> shAmt);
    end else begin
      shfRes = srcF[0] >> shAmt;
    end
  end

  // result unit select
  always_comb begin
    if (strb.selAlu) begin
      unitRes = aluRes;
    end else if (strb.selCmp) begin
      unitRes = {{(W-1){1'b0}}, sltBit};
    end else if (strb.selShf) begin
      unitRes = shfRes;
    end else begin
      unitRes = '0;
    end
  end

  // execute/write-back register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outRd     <= '0;
      outResult <= '0;
      memAddr   <= '0;
      memWdata  <= '0;
      memRdEn   <= 1'b0;
      memWrEn   <= 1'b0;
      brEn      <= 1'b0;
      brAddr    <= '0;
      mdStart   <= 1'b0;
      mdOpA     <= '0;
      mdOpB     <= '0;
    end else begin
      outValid  <= strb.wrResult;
      outRd     <= inRd;
      outResult <= unitRes;
      memAddr   <= aluRes;
      memWdata  <= srcF[1];
      memRdEn   <= strb.memRd;
      memWrEn   <= strb.memWr;
      brEn      <= strb.isBranch && brTaken;
      brAddr    <= aluRes;
      mdStart   <= strb.mdGo;
      mdOpA     <= srcF[0];
      mdOpB     <= srcF[1];
    end
  end

  p_br_only_branch_r7: assert property (@(posedge clk) disable iff (!rstN)
    brEn |-> $past(strb.isBranch));

  p_target_is_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    brEn |-> (brAddr == memAddr));

  p_wr_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!memRdEn && !memWrEn && !brEn && !mdStart));

endmodule

// File: rtl/exec_stage.sv
module exec_stage import exec_pkg::*; #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [3:0]    inOp,
  input  logic [2:0]    inBrType,
  input  logic          inIsBranch,
  input  logic          inMemRd,
  input  logic          inMemWr,
  input  logic          inSelPc,
  input  logic          inSelImm,
  input  logic [W-1:0]  inPc,
  input  logic [W-1:0]  inImm,
  input  logic [RW-1:0] rs1Idx,
  input  logic [W-1:0]  rs1Val,
  input  logic          rs1Ready,
  input  logic [RW-1:0] rs2Idx,
  input  logic [W-1:0]  rs2Val,
  input  logic          rs2Ready,
  input  logic [RW-1:0] inRd,
  input  logic          wbWrEn,
  input  logic [RW-1:0] wbRd,
  input  logic [W-1:0]  wbVal,
  input  logic          mdDone,
  output logic          outValid,
  output logic [RW-1:0] outRd,
  output logic [W-1:0]  outResult,
  output logic [W-1:0]  memAddr,
  output logic [W-1:0]  memWdata,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic          brEn,
  output logic [W-1:0]  brAddr,
  output logic          mdStart,
  output logic [W-1:0]  mdOpA,
  output logic [W-1:0]  mdOpB
);

  strobes_t strb;

  exec_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inOp       (inOp),
    .inBrType   (inBrType),
    .inIsBranch (inIsBranch),
    .inMemRd    (inMemRd),
    .inMemWr    (inMemWr),
    .inSelPc    (inSelPc),
    .inSelImm   (inSelImm),
    .mdDone     (mdDone),
    .strb       (strb)
  );

  exec_dp #(.W(W), .RW(RW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .inPc      (inPc),
    .inImm     (inImm),
    .srcIdx    ({rs2Idx, rs1Idx}),
    .srcVal    ({rs2Val, rs1Val}),
    .srcReady  ({rs2Ready, rs1Ready}),
    .inRd      (inRd),
    .wbWrEn    (wbWrEn),
    .wbRd      (wbRd),
    .wbVal     (wbVal),
    .outValid  (outValid),
    .outRd     (outRd),
    .outResult (outResult),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .brEn      (brEn),
    .brAddr    (brAddr),
    .mdStart   (mdStart),
    .mdOpA     (mdOpA),
    .mdOpB     (mdOpB)
  );

endmodule

// File: tb/exec_stage_tb.sv
`timescale 1ns/1ps
module exec_stage_tb_top;

  typedef struct {
    logic        valid;
    logic [3:0]  op;
    logic [2:0]  brType;
    logic        isBr, memRd, memWr, selPc, selImm;
    logic [31:0] pc, imm;
    logic [4:0]  i1, i2, rd;
    logic [31:0] v1, v2;
    logic        r1, r2;
    logic        wbWe;
    logic [4:0]  wbRd;
    logic [31:0] wbVal;
    logic        done;
  } stim_t;

  typedef struct {
    string       tag;
    logic        valid;
    logic [4:0]  rd;
    logic [31:0] result, addr, wdata, target, mdA, mdB;
    logic        re, we, br, isBr, md;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inIsBranch, inMemRd, inMemWr, inSelPc, inSelImm;
  logic [3:0]  inOp;
  logic [2:0]  inBrType;
  logic [31:0] inPc, inImm, rs1Val, rs2Val, wbVal;
  logic [4:0]  rs1Idx, rs2Idx, inRd, wbRd;
  logic        rs1Ready, rs2Ready, wbWrEn, mdDone;
  logic        outValid, memRdEn, memWrEn, brEn, mdStart;
  logic [4:0]  outRd;
  logic [31:0] outResult, memAddr, memWdata, brAddr, mdOpA, mdOpB;

  int total = 0;
  int bad = 0;
  exp_t scoreQ[$];
  logic pendModel = 1'b0;

  always #2 clk = ~clk;

  exec_stage dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inBrType(inBrType),
    .inIsBranch(inIsBranch), .inMemRd(inMemRd), .inMemWr(inMemWr),
    .inSelPc(inSelPc), .inSelImm(inSelImm), .inPc(inPc), .inImm(inImm),
    .rs1Idx(rs1Idx), .rs1Val(rs1Val), .rs1Ready(rs1Ready),
    .rs2Idx(rs2Idx), .rs2Val(rs2Val), .rs2Ready(rs2Ready), .inRd(inRd),
    .wbWrEn(wbWrEn), .wbRd(wbRd), .wbVal(wbVal), .mdDone(mdDone),
    .outValid(outValid), .outRd(outRd), .outResult(outResult),
    .memAddr(memAddr), .memWdata(memWdata), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .brEn(brEn), .brAddr(brAddr), .mdStart(mdStart), .mdOpA(mdOpA), .mdOpB(mdOpB)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic stim_t idle();
    stim_t s;
    s.valid = 0; s.op = 0; s.brType = 0; s.isBr = 0; s.memRd = 0; s.memWr = 0;
    s.selPc = 0; s.selImm = 0; s.pc = 0; s.imm = 0; s.i1 = 0; s.i2 = 0; s.rd = 0;
    s.v1 = 0; s.v2 = 0; s.r1 = 1; s.r2 = 1; s.wbWe = 0; s.wbRd = 0; s.wbVal = 0;
    s.done = 0;
    return s;
  endfunction

  function automatic stim_t alu(input logic [3:0] op, input logic [31:0] a,
                                input logic [31:0] b);
    stim_t s = idle();
    s.valid = 1; s.op = op; s.i1 = 5'd3; s.i2 = 5'd4; s.rd = 5'd9;
    s.v1 = a; s.v2 = b;
    return s;
  endfunction

  // reference model, written from the requirement list
  function automatic exp_t model(input stim_t s, input string tag, input logic pend);
    exp_t e;
    logic [31:0] f1, f2, a, b;
    logic taken;
    f1 = (!s.r1 && s.wbWe && s.wbRd == s.i1 && s.i1 != 0) ? s.wbVal : s.v1;
    f2 = (!s.r2 && s.wbWe && s.wbRd == s.i2 && s.i2 != 0) ? s.wbVal : s.v2;
    a = s.selPc ? s.pc : f1;
    b = s.selImm ? s.imm : f2;
    e.tag = tag;
    case (s.op)
      4'd0: e.result = a + b;
      4'd1: e.result = a - b;
      4'd2: e.result = a & b;
      4'd3: e.result = a | b;
      4'd4: e.result = a ^ b;
      4'd5: e.result = {31'd0, $signed(f1) < $signed(b)};
      4'd6: e.result = {31'd0, f1 < b};
      4'd7: e.result = f1 << b[4:0];
      4'd8: e.result = f1 >> b[4:0];
      4'd9: e.result = 32'($signed(f1) >>> b[4:0]);
      default: e.result = 0;
    endcase
    e.valid  = s.valid && s.op <= 4'd9 && !s.isBr && !s.memRd && !s.memWr;
    e.rd     = s.rd;
    e.addr   = a + b;
    e.target = a + b;
    e.wdata  = f2;
    e.re     = s.valid && s.memRd;
    e.we     = s.valid && s.memWr;
    case (s.brType)
      3'd0: taken = (f1 == f2);
      3'd1: taken = (f1 != f2);
      3'd4: taken = $signed(f1) < $signed(f2);
      3'd5: taken = $signed(f1) >= $signed(f2);
      3'd6: taken = f1 < f2;
      3'd7: taken = f1 >= f2;
      default: taken = 0;
    endcase
    e.isBr = s.valid && s.isBr;
    e.br   = e.isBr && taken;
    e.md   = s.valid && s.op == 4'd10 && (!pend || s.done);
    e.mdA  = f1;
    e.mdB  = f2;
    return e;
  endfunction

  task automatic issue(input stim_t s, input string tag);
    @(negedge clk);
    inValid = s.valid; inOp = s.op; inBrType = s.brType; inIsBranch = s.isBr;
    inMemRd = s.memRd; inMemWr = s.memWr; inSelPc = s.selPc; inSelImm = s.selImm;
    inPc = s.pc; inImm = s.imm; rs1Idx = s.i1; rs2Idx = s.i2; inRd = s.rd;
    rs1Val = s.v1; rs2Val = s.v2; rs1Ready = s.r1; rs2Ready = s.r2;
    wbWrEn = s.wbWe; wbRd = s.wbRd; wbVal = s.wbVal; mdDone = s.done;
    scoreQ.push_back(model(s, tag, pendModel));
    if (s.valid && s.op == 4'd10 && (!pendModel || s.done)) pendModel = 1'b1;
    else if (s.done) pendModel = 1'b0;
  endtask

  // monitor: one expectation per cycle, due one edge after the drive
  always @(posedge clk) begin
    #1;
    if (rstN && scoreQ.size() > 0) begin
      exp_t e;
      e = scoreQ.pop_front();
      chk(e.tag, "outValid", 32'(outValid), 32'(e.valid));
      chk(e.tag, "memRdEn", 32'(memRdEn), 32'(e.re));
      chk(e.tag, "memWrEn", 32'(memWrEn), 32'(e.we));
      chk(e.tag, "brEn", 32'(brEn), 32'(e.br));
      chk(e.tag, "mdStart", 32'(mdStart), 32'(e.md));
      if (e.valid) begin
        chk(e.tag, "outResult", outResult, e.result);
        chk(e.tag, "outRd", 32'(outRd), 32'(e.rd));
      end
      if (e.re || e.we) chk(e.tag, "memAddr", memAddr, e.addr);
      if (e.we) chk(e.tag, "memWdata", memWdata, e.wdata);
      if (e.isBr) chk(e.tag, "brAddr", brAddr, e.target);
      if (e.md) begin
        chk(e.tag, "mdOpA", mdOpA, e.mdA);
        chk(e.tag, "mdOpB", mdOpB, e.mdB);
      end
    end
  end

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t s;
    rstN = 1'b0;
    s = idle();
    inValid = 0; inOp = 0; inBrType = 0; inIsBranch = 0; inMemRd = 0; inMemWr = 0;
    inSelPc = 0; inSelImm = 0; inPc = 0; inImm = 0; rs1Idx = 0; rs2Idx = 0; inRd = 0;
    rs1Val = 0; rs2Val = 0; rs1Ready = 1; rs2Ready = 1; wbWrEn = 0; wbRd = 0;
    wbVal = 0; mdDone = 0;
    // R11: drive a busy-looking instruction during reset, outputs must stay zero
    @(negedge clk);
    inValid = 1; inIsBranch = 1; inMemWr = 1; inOp = 4'd10; rs1Val = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "outValid", 32'(outValid), 0);
    chk("R11", "brEn", 32'(brEn), 0);
    chk("R11", "memWrEn", 32'(memWrEn), 0);
    chk("R11", "mdStart", 32'(mdStart), 0);
    chk("R11", "outResult", outResult, 0);
    chk("R11", "mdOpA", mdOpA, 0);
    inValid = 0; inIsBranch = 0; inMemWr = 0; inOp = 0; rs1Val = 0;
    rstN = 1'b1;

    // R1 arithmetic and logic
    issue(alu(4'd0, 32'h7FFF_FFFF, 32'd1), "R1 add");
    issue(alu(4'd1, 32'd0, 32'd1), "R1 sub wrap");
    issue(alu(4'd2, 32'hF0F0_1234, 32'h0FF0_FF00), "R1 and");
    issue(alu(4'd3, 32'hF000_0001, 32'h0000_0F10), "R1 or");
    issue(alu(4'd4, 32'hAAAA_5555, 32'hFFFF_0000), "R1 xor");
    s = alu(4'd0, 32'd5, 32'd0); s.selImm = 1; s.imm = 32'hFFFF_FFFE;
    issue(s, "R1 add imm");
    // R3 comparisons
    issue(alu(4'd5, 32'hFFFF_FFFF, 32'd1), "R3 slt neg");
    issue(alu(4'd6, 32'hFFFF_FFFF, 32'd1), "R3 sltu big");
    issue(alu(4'd5, 32'd7, 32'd7), "R3 slt equal");
    // R4 shifts
    issue(alu(4'd7, 32'h8000_0003, 32'd33), "R4 sll low5");
    issue(alu(4'd8, 32'h8000_0000, 32'd4), "R4 srl");
    issue(alu(4'd9, 32'h8000_0000, 32'd4), "R4 sra");
    issue(alu(4'd9, 32'h4000_0000, 32'd31), "R4 sra pos");
    // R8 unlisted opcode never writes
    issue(alu(4'd12, 32'd1, 32'd2), "R8 bad opcode");
    s = alu(4'd0, 32'd1, 32'd2); s.valid = 0;
    issue(s, "R8 not valid");
    // R2 forwarding
    s = alu(4'd0, 32'd10, 32'd20); s.r1 = 0; s.wbWe = 1; s.wbRd = 5'd3; s.wbVal = 32'd100;
    issue(s, "R2 fwd rs1");
    s = alu(4'd0, 32'd10, 32'd20); s.r2 = 0; s.wbWe = 1; s.wbRd = 5'd4; s.wbVal = 32'd300;
    issue(s, "R2 fwd rs2");
    s = alu(4'd0, 32'd10, 32'd20); s.r1 = 1; s.wbWe = 1; s.wbRd = 5'd3; s.wbVal = 32'd100;
    issue(s, "R2 ready no fwd");
    s = alu(4'd0, 32'd10, 32'd20); s.i1 = 0; s.r1 = 0; s.wbWe = 1; s.wbRd = 0; s.wbVal = 32'd100;
    issue(s, "R2 zero index");
    s = alu(4'd0, 32'd10, 32'd20); s.r1 = 0; s.wbWe = 1; s.wbRd = 5'd8; s.wbVal = 32'd100;
    issue(s, "R2 mismatch");
    s = alu(4'd0, 32'd10, 32'd20); s.r1 = 0; s.wbWe = 0; s.wbRd = 5'd3; s.wbVal = 32'd100;
    issue(s, "R2 no wb write");
    // R5 memory
    s = alu(4'd0, 32'h1000, 32'hDEAD_BEEF); s.selImm = 1; s.imm = 32'h24; s.memWr = 1;
    s.r2 = 0; s.wbWe = 1; s.wbRd = 5'd4; s.wbVal = 32'hCAFE_0001;
    issue(s, "R5 store fwd data");
    s = alu(4'd0, 32'h2000, 32'd0); s.selImm = 1; s.imm = 32'hFFFF_FFFC; s.memRd = 1;
    issue(s, "R5 load");
    s = alu(4'd0, 32'h2000, 32'd0); s.memWr = 1; s.valid = 0;
    issue(s, "R5 store not valid");
    // R6 and R7 branches, every type with taken and not-taken operands
    for (int t = 0; t < 8; t++) begin
      s = alu(4'd0, 32'hFFFF_FFF0, 32'd5); s.isBr = 1; s.brType = 3'(t);
      s.selPc = 1; s.selImm = 1; s.pc = 32'h400; s.imm = 32'hFFFF_FFF8;
      issue(s, "R7 branch neg/pos R6");
      s.v1 = 32'd9; s.v2 = 32'd9;
      issue(s, "R7 branch equal R6");
      s.v1 = 32'd2; s.v2 = 32'h8000_0000;
      issue(s, "R7 branch pos/neg R6");
    end
    s = alu(4'd0, 32'd1, 32'd1); s.brType = 3'd0; s.isBr = 0;
    issue(s, "R7 not branch");
    s = alu(4'd0, 32'd1, 32'd1); s.brType = 3'd0; s.isBr = 1; s.valid = 0;
    issue(s, "R7 branch not valid");
    // R9 and R10 multiply/divide handshake
    s = alu(4'd10, 32'd6, 32'd7); s.r1 = 0; s.wbWe = 1; s.wbRd = 5'd3; s.wbVal = 32'd60;
    issue(s, "R9 md start fwd");
    issue(alu(4'd10, 32'd1, 32'd2), "R10 md busy");
    issue(idle(), "R10 idle busy");
    s = alu(4'd10, 32'd3, 32'd4); s.done = 1;
    issue(s, "R10 md done same cycle");
    s = idle(); s.done = 1;
    issue(s, "R10 done clears");
    issue(alu(4'd10, 32'd8, 32'd9), "R9 md after clear");
    repeat (3) issue(idle(), "idle");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule